// File: doc/BRIEF.md
# Display Driver Power Control Register

This block is a host-writable power control register for a display driver controller. It holds four control bits: an analog amplifier enable, a power-saving halt, a booster enable and a self-clearing initialization request. The host writes a command byte on a parallel bus. The upper nibble of the byte is a fixed register-select code, and the lower nibble holds the four bits. The host reads the register back at that same code.

Setting the initialization bit on a master device starts an internal reset pulse. The pulse is timed by the display clock and lasts a fixed number of display clock cycles. The request crosses into the display clock domain through a toggle handshake. The bit clears itself once the pulse has started. A busy flag stays high until the pulse has finished, and the register ignores writes for as long as busy is high.

On a slave device, selected by a strap input, the initialization bit has no effect. Halt stops the oscillator, amplifier and booster enables and closes the display clock gate. It also forces every segment and common output to logic 0. Clearing halt restores the previous state.

Top module: `pctl_power_reg`

## Requirements
- R1: After reset all four bits are 0, so a read returns the register-select code in the upper nibble and 0 in the lower nibble. In that state busy and soft_rst are 0, and osc_en, dclk_gate_en and drive_en are 1 while amp_en and boost_en are 0.
- R2: A write whose upper nibble equals REG_CODE (default 0xB) loads amplifier enable from bit 3, halt from bit 2 and booster enable from bit 1. A write with any other upper nibble changes nothing.
- R3: A read with rd_addr equal to REG_CODE returns {REG_CODE, amp, halt, boost, init} on rd_data, with rd_valid high, one clock after rd_en. Any other rd_addr gives rd_valid low.
- R4: One clock after a register update, boost_en equals the booster bit and amp_en equals the amplifier bit, both while halt is 0.
- R5: While halt is 1, osc_en, amp_en, boost_en, dclk_gate_en and drive_en are 0 and seg_out and com_out are all zeros. These outputs take effect one clock after halt is set.
- R6: Clearing halt restores osc_en, dclk_gate_en, drive_en, the stored amplifier and booster enables, and the pass-through of seg_in and com_in, without a soft reset.
- R7: On a master device, writing bit 0 = 1 produces exactly one soft_rst pulse that is high for RST_CYCLES display clock cycles (RST_CYCLES of at least 2).
- R8: busy is high from the clock after an accepted initialization write until the pulse has ended. After that, a read returns bit 0 as 0.
- R9: When is_master is 0, bit 0 of a write is ignored: no busy and no pulse. The other three bits are still loaded.
- R10: A write that arrives while busy is 1 is ignored entirely.
- R11: An initialization request is ignored while halt is already 1, and also when the same write sets halt. The display clock is blocked in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, always running |
| rst | input | 1 | Synchronous active-high hardware reset |
| dclk | input | 1 | Display clock that times the reset pulse |
| is_master | input | 1 | Strap: 1 master, 0 slave |
| wr_en | input | 1 | Write strobe for one host clock |
| wr_data | input | CODE_W+4 | Command byte: select code and four control bits |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | CODE_W | Register code being read |
| rd_data | output | CODE_W+4 | Registered read data |
| rd_valid | output | 1 | High for one clock when rd_data holds this register |
| busy | output | 1 | Initialization in progress; writes ignored |
| soft_rst | output | 1 | Internal reset pulse in the display clock domain |
| osc_en | output | 1 | Oscillator and supply enable |
| amp_en | output | 1 | Analog amplifier enable |
| boost_en | output | 1 | Booster enable |
| dclk_gate_en | output | 1 | Enable for the downstream display clock gate |
| drive_en | output | 1 | Display drive waveform enable |
| seg_in | input | SEG_W | Segment drive levels from the waveform logic |
| com_in | input | COM_W | Common drive levels from the waveform logic |
| seg_out | output | SEG_W | Segment outputs, forced low in halt |
| com_out | output | COM_W | Common outputs, forced low in halt |

## Verification
The bench builds the block with SEG_W=16, COM_W=8, RST_CYCLES=3 and two synchronizer stages, running the display clock at a period unrelated to the host clock. With a three-cycle pulse, an off-by-one in the sequencer counter shows up as a measurable width error rather than hitting a floor. The narrow output buses let full segment and common patterns be compared in every halt state. The unrelated clock ratio also exercises both toggle crossings at shifting phases.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
  typedef struct packed {
    logic amp_on;
    logic halt;
    logic boost_on;
    logic init_req;
  } pctl_bits_t;

  localparam int AMP_BIT   = 3;
  localparam int HALT_BIT  = 2;
  localparam int BOOST_BIT = 1;
  localparam int INIT_BIT  = 0;
endpackage

// File: rtl/pctl_sync.sv
module pctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= RST_VAL;
        else     chain_q <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= {STAGES{RST_VAL}};
        else     chain_q <= {chain_q[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/pctl_rst_seq.sv
module pctl_rst_seq #(
  parameter int RST_CYCLES = 2
) (
  input  logic dclk,
  input  logic drst,
  input  logic req_tgl_s,
  output logic ack_tgl,
  output logic done_tgl,
  output logic soft_rst
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             seen_q;
  logic             ack_q;
  logic             done_q;
  logic             pulse_q;

  always_ff @(posedge dclk) begin
    if (drst) begin
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      ack_q   <= 1'b0;
      done_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else if (cnt_q == '0) begin
      if (req_tgl_s != seen_q) begin
        seen_q  <= req_tgl_s;
        cnt_q   <= CNT_W'(RST_CYCLES);
        pulse_q <= 1'b1;
        ack_q   <= ~ack_q;
      end
    end else if (cnt_q == CNT_W'(1)) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
      done_q  <= ~done_q;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign ack_tgl  = ack_q;
  assign done_tgl = done_q;
  assign soft_rst = pulse_q;

  AST_PULSE_MIN_WIDTH: assert property (@(posedge dclk) disable iff (drst)
    $fell(pulse_q) |-> $past(pulse_q, 2)); // R7
endmodule

// File: rtl/pctl_regs.sv
module pctl_regs
  import pctl_pkg::*;
#(
  parameter int                CODE_W   = 4,
  parameter logic [CODE_W-1:0] REG_CODE = 4'hB,
  localparam int               DATA_W   = CODE_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              is_master,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_addr,
  input  logic              ack_tgl_s,
  input  logic              done_tgl_s,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              req_tgl,
  output logic              busy,
  output pctl_bits_t        bits
);
  pctl_bits_t        bits_q;
  logic              req_q;
  logic              ack_seen_q;
  logic              busy_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  logic wr_hit;
  logic init_go;
  logic ack_edge;

  always_comb begin
    wr_hit   = wr_en && (wr_data[DATA_W-1 -: CODE_W] == REG_CODE) && !busy_q;
    init_go  = wr_hit && wr_data[INIT_BIT] && is_master &&
               !wr_data[HALT_BIT] && !bits_q.halt;
    ack_edge = ack_tgl_s != ack_seen_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q     <= '0;
      req_q      <= 1'b0;
      ack_seen_q <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      ack_seen_q <= ack_tgl_s;
      if (wr_hit) begin
        bits_q.amp_on   <= wr_data[AMP_BIT];
        bits_q.halt     <= wr_data[HALT_BIT];
        bits_q.boost_on <= wr_data[BOOST_BIT];
      end
      if (init_go) begin
        bits_q.init_req <= 1'b1;
        req_q           <= ~req_q;
      end else if (ack_edge) begin
        bits_q.init_req <= 1'b0;
      end
      busy_q <= init_go || bits_q.init_req || (req_q != done_tgl_s);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else if (rd_en && (rd_addr == REG_CODE)) begin
      rd_data_q  <= {REG_CODE, bits_q};
      rd_valid_q <= 1'b1;
    end else begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign req_tgl  = req_q;
  assign busy     = busy_q;
  assign bits     = bits_q;

  AST_INIT_HOLDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    bits_q.init_req |-> busy_q); // R8
  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && busy_q) |=> $stable({bits_q.amp_on, bits_q.halt, bits_q.boost_on})); // R10
  AST_SLAVE_NO_INIT: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(is_master)); // R9
  AST_HALT_NO_INIT: assert property (@(posedge clk) disable iff (rst)
    $rose(bits_q.init_req) |-> !$past(bits_q.halt)); // R11
endmodule

// File: rtl/pctl_drive.sv
module pctl_drive
  import pctl_pkg::*;
#(
  parameter int SEG_W = 128,
  parameter int COM_W = 130
) (
  input  logic             clk,
  input  logic             rst,
  input  pctl_bits_t       bits,
  input  logic [SEG_W-1:0] seg_in,
  input  logic [COM_W-1:0] com_in,
  output logic             osc_en,
  output logic             amp_en,
  output logic             boost_en,
  output logic             dclk_gate_en,
  output logic             drive_en,
  output logic [SEG_W-1:0] seg_out,
  output logic [COM_W-1:0] com_out
);
  logic             osc_q;
  logic             amp_q;
  logic             boost_q;
  logic             gate_q;
  logic             drive_q;
  logic [SEG_W-1:0] seg_q;
  logic [COM_W-1:0] com_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      osc_q   <= 1'b1;
      amp_q   <= 1'b0;
      boost_q <= 1'b0;
      gate_q  <= 1'b1;
      drive_q <= 1'b1;
      seg_q   <= '0;
      com_q   <= '0;
    end else begin
      osc_q   <= !bits.halt;
      amp_q   <= bits.amp_on && !bits.halt;
      boost_q <= bits.boost_on && !bits.halt;
      gate_q  <= !bits.halt;
      drive_q <= !bits.halt;
      seg_q   <= bits.halt ? '0 : seg_in;
      com_q   <= bits.halt ? '0 : com_in;
    end
  end

  assign osc_en       = osc_q;
  assign amp_en       = amp_q;
  assign boost_en     = boost_q;
  assign dclk_gate_en = gate_q;
  assign drive_en     = drive_q;
  assign seg_out      = seg_q;
  assign com_out      = com_q;

  AST_HALT_FORCES_LOW: assert property (@(posedge clk) disable iff (rst)
    bits.halt |=> (!osc_q && !amp_q && !boost_q && !gate_q && !drive_q &&
                   seg_q == '0 && com_q == '0)); // R5
  AST_RESUME_ENABLES: assert property (@(posedge clk) disable iff (rst)
    $fell(bits.halt) |=> (osc_q && gate_q && drive_q)); // R6
endmodule

// File: rtl/pctl_power_reg.sv
module pctl_power_reg
  import pctl_pkg::*;
#(
  parameter int                CODE_W      = 4,
  parameter logic [CODE_W-1:0] REG_CODE    = 4'hB,
  parameter int                RST_CYCLES  = 2,
  parameter int                SYNC_STAGES = 2,
  parameter int                SEG_W       = 128,
  parameter int                COM_W       = 130,
  localparam int               DATA_W      = CODE_W + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              dclk,
  input  logic              is_master,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [CODE_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              soft_rst,
  output logic              osc_en,
  output logic              amp_en,
  output logic              boost_en,
  output logic              dclk_gate_en,
  output logic              drive_en,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [COM_W-1:0]  com_in,
  output logic [SEG_W-1:0]  seg_out,
  output logic [COM_W-1:0]  com_out
);
  pctl_bits_t bits;
  logic       drst;
  logic       req_tgl;
  logic       req_tgl_s;
  logic       ack_tgl;
  logic       ack_tgl_s;
  logic       done_tgl;
  logic       done_tgl_s;

  pctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_drst_sync (
    .clk(dclk), .rst(1'b0), .d(rst), .q(drst)
  );
  pctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_req_sync (
    .clk(dclk), .rst(drst), .d(req_tgl), .q(req_tgl_s)
  );
  pctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ack_sync (
    .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_tgl_s)
  );
  pctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_done_sync (
    .clk(clk), .rst(rst), .d(done_tgl), .q(done_tgl_s)
  );

  pctl_regs #(.CODE_W(CODE_W), .REG_CODE(REG_CODE)) u_regs (
    .clk(clk), .rst(rst), .is_master(is_master),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .ack_tgl_s(ack_tgl_s), .done_tgl_s(done_tgl_s),
    .rd_data(rd_data), .rd_valid(rd_valid), .req_tgl(req_tgl),
    .busy(busy), .bits(bits)
  );

  pctl_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_seq (
    .dclk(dclk), .drst(drst), .req_tgl_s(req_tgl_s),
    .ack_tgl(ack_tgl), .done_tgl(done_tgl), .soft_rst(soft_rst)
  );

  pctl_drive #(.SEG_W(SEG_W), .COM_W(COM_W)) u_drive (
    .clk(clk), .rst(rst), .bits(bits), .seg_in(seg_in), .com_in(com_in),
    .osc_en(osc_en), .amp_en(amp_en), .boost_en(boost_en),
    .dclk_gate_en(dclk_gate_en), .drive_en(drive_en),
    .seg_out(seg_out), .com_out(com_out)
  );
endmodule

// File: tb/pctl_power_reg_tb.sv
module pctl_power_reg_tb;
  localparam int CLK_PERIOD  = 10;
  localparam int DCLK_PERIOD = 26;
  localparam int SEG_W       = 16;
  localparam int COM_W       = 8;
  localparam int RST_CYC     = 3;
  localparam logic [SEG_W-1:0] SEG_PAT = 16'hA5C3;
  localparam logic [COM_W-1:0] COM_PAT = 8'h5A;

  // {master, wdata, expected read, expected {osc,amp,boost,gate,drive}}
  localparam logic [21:0] VEC [0:7] = '{
    {1'b1, 8'hB8, 8'hB8, 5'b11011},
    {1'b1, 8'hBA, 8'hBA, 5'b11111},
    {1'b1, 8'h3F, 8'hBA, 5'b11111},
    {1'b1, 8'hBE, 8'hBE, 5'b00000},
    {1'b1, 8'hB2, 8'hB2, 5'b10111},
    {1'b0, 8'hBB, 8'hBA, 5'b11111},
    {1'b0, 8'hB0, 8'hB0, 5'b10011},
    {1'b1, 8'h03, 8'hB0, 5'b10011}
  };

  logic clk = 1'b0, dclk = 1'b0, rst = 1'b1;
  logic is_master = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic rd_valid, busy, soft_rst, osc_en, amp_en, boost_en, dclk_gate_en, drive_en;
  logic [SEG_W-1:0] seg_in = '0, seg_out;
  logic [COM_W-1:0] com_in = '0, com_out;

  int checks = 0, failures = 0;
  int pulses = 0, run_len = 0, last_width = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always #(DCLK_PERIOD/2) dclk = ~dclk;

  pctl_power_reg #(.RST_CYCLES(RST_CYC), .SYNC_STAGES(2), .SEG_W(SEG_W), .COM_W(COM_W)) u_dut (
    .clk(clk), .rst(rst), .dclk(dclk), .is_master(is_master),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy), .soft_rst(soft_rst),
    .osc_en(osc_en), .amp_en(amp_en), .boost_en(boost_en),
    .dclk_gate_en(dclk_gate_en), .drive_en(drive_en),
    .seg_in(seg_in), .com_in(com_in), .seg_out(seg_out), .com_out(com_out)
  );

  always @(negedge dclk) begin
    if (soft_rst) run_len = run_len + 1;
    else if (run_len != 0) begin
      last_width = run_len;
      pulses = pulses + 1;
      run_len = 0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_read(input logic [3:0] a);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 500 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [4:0] outs();
    return {osc_en, amp_en, boost_en, dclk_gate_en, drive_en};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int p0;
    repeat (20) @(negedge clk);
    rst = 1'b0;
    seg_in = SEG_PAT; com_in = COM_PAT;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 soft_rst", soft_rst, 0);
    @(negedge clk);
    chk("R1 enables", outs(), 5'b10011);
    do_read(4'hB);
    chk("R1 readback", rd_data, 8'hB0);
    chk("R3 rd_valid", rd_valid, 1);
    do_read(4'h3);
    chk("R3 other addr rd_valid", rd_valid, 0);

    // R2 R4 R5 R6 R9 vector walk
    for (int v = 0; v < 8; v++) begin
      is_master = VEC[v][21];
      p0 = pulses;
      do_write(VEC[v][20:13]);
      @(negedge clk);
      chk("R4/R5/R6 enables", outs(), VEC[v][4:0]);
      chk("R5/R6 seg_out", seg_out, VEC[v][7] ? '0 : SEG_PAT);
      chk("R5/R6 com_out", com_out, VEC[v][7] ? '0 : COM_PAT);
      chk("R9 busy stays low", busy, 0);
      do_read(4'hB);
      chk("R2/R3 readback", rd_data, VEC[v][12:5]);
      repeat (10) @(negedge clk);
      chk("R9 no pulse", pulses, p0);
    end

    // R7 R8 master initialization
    is_master = 1'b1;
    p0 = pulses;
    do_write(8'hB1);
    chk("R8 busy after init write", busy, 1);
    wait_idle();
    chk("R8 busy drops", busy, 0);
    chk("R7 one pulse", pulses, p0 + 1);
    chk("R7 pulse width", last_width, RST_CYC);
    do_read(4'hB);
    chk("R8 init bit self-clears", rd_data, 8'hB0);

    // R10 write during busy ignored
    p0 = pulses;
    do_write(8'hB1);
    do_write(8'hBC);
    wait_idle();
    do_read(4'hB);
    chk("R10 write ignored", rd_data, 8'hB0);
    chk("R10 enables unchanged", outs(), 5'b10011);
    chk("R10 single pulse", pulses, p0 + 1);

    // R11 init with halt in same write, then while halted
    p0 = pulses;
    do_write(8'hB5);
    chk("R11 busy low", busy, 0);
    do_write(8'hB5);
    repeat (30) @(negedge clk);
    chk("R11 no pulse", pulses, p0);
    do_read(4'hB);
    chk("R11 readback", rd_data, 8'hB4);
    chk("R5 halted outputs", outs(), 5'b00000);
    do_write(8'hB0);
    @(negedge clk);
    chk("R6 resume", outs(), 5'b10011);
    chk("R6 seg resume", seg_out, SEG_PAT);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule